// File: doc/BRIEF.md
# Conditional trap comparator

This block decides whether a conditional trap instruction must raise a program trap. When it is started, it compares two operands. It forms five relations at once: signed less-than, signed greater-than, equality, unsigned less-than and unsigned greater-than. A 5-bit condition mask selects which of these relations count. If any selected relation holds, the block reports a trap.

A mode input picks the operand width. The word form looks only at the low half of each operand and treats the top bit of that half as the sign. The doubleword form compares the full operands. The trap result and its sub-cause code are registered. A one-cycle done strobe follows each start. The block only reports the trap; delivering the exception is left to the surrounding pipeline.

Top module: `trap_compare`

## Requirements
- R1: Mask bit 4 (value 0x10) enables a trap when operand A is less than operand B, with both read as two's-complement signed numbers.
- R2: Mask bit 3 (value 0x08) enables a trap when A is greater than B, with both read as signed numbers.
- R3: Mask bit 2 (value 0x04) enables a trap when A equals B.
- R4: Mask bit 1 (value 0x02) enables a trap when A is less than B, with both read as unsigned numbers.
- R5: Mask bit 0 (value 0x01) enables a trap when A is greater than B, with both read as unsigned numbers.
- R6: The trap flag is the OR of every relation whose mask bit is set.
- R7: With `dword` low (word form), only bits 31:0 of each operand take part, and bit 31 is the sign. Bits 63:32 have no effect on the result.
- R8: With `dword` high (doubleword form), all 64 bits take part, and bit 63 is the sign.
- R9: A mask of 0x00 never traps. A mask of 0x1F always traps.
- R10: `done` is high for exactly one cycle, the cycle after `start` is sampled. `trap` and `cause` keep the last result until the next start.
- R11: `cause` equals the trap sub-cause code (default 4'h2) when `trap` is high, and 0 otherwise.
- R12: After reset, `done`, `trap` and `cause` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Evaluate the operands this cycle |
| dword | input | 1 | 1 = full-width compare, 0 = low-half (word) compare |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| cond_mask | input | 5 | Relation enables, bit 4 down to bit 0: s<, s>, ==, u<, u> |
| done | output | 1 | One-cycle result strobe |
| trap | output | 1 | A trap must be raised |
| cause | output | 4 | Trap sub-cause code, or 0 when there is no trap |

## Verification
The bench builds the block with its default parameters: 64-bit operands, a 32-bit word half and a 4-bit cause code. Both sign positions are therefore in play. Operand pairs are chosen so that the word form and the doubleword form give opposite answers: the upper half differs while the low halves match, and bit 31 is set while bit 63 is clear. Signed and unsigned orderings are also pulled apart with operands such as -1 against 1. Several hundred pseudo-random operand, mask and mode combinations are then compared against an independent 32-bit and 64-bit model.

// File: rtl/trap_compare.sv
module trap_compare #(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32,
  parameter int CODE_W = 4,
  parameter logic [CODE_W-1:0] TRAP_CODE = 4'h2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dword,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [4:0]        cond_mask,
  output logic              done,
  output logic              trap,
  output logic [CODE_W-1:0] cause
);
  localparam int PAD_W = DATA_W - WORD_W;

  logic [DATA_W-1:0] a_u, b_u, a_s, b_s;
  logic [4:0]        rel;
  logic              hit;

  // word form: zero-extend for unsigned, sign-extend from bit WORD_W-1 for signed
  assign a_u = dword ? opa : {{PAD_W{1'b0}}, opa[WORD_W-1:0]};
  assign b_u = dword ? opb : {{PAD_W{1'b0}}, opb[WORD_W-1:0]};
  assign a_s = dword ? opa : {{PAD_W{opa[WORD_W-1]}}, opa[WORD_W-1:0]};
  assign b_s = dword ? opb : {{PAD_W{opb[WORD_W-1]}}, opb[WORD_W-1:0]};

  assign rel[4] = $signed(a_s) < $signed(b_s);
  assign rel[3] = $signed(a_s) > $signed(b_s);
  assign rel[2] = a_u == b_u;
  assign rel[1] = a_u < b_u;
  assign rel[0] = a_u > b_u;

  assign hit = |(rel & cond_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done  <= 1'b0;
      trap  <= 1'b0;
      cause <= '0;
    end else begin
      done <= start;
      if (start) begin
        trap  <= hit;
        cause <= hit ? TRAP_CODE : '0;
      end
    end
  end

  a_r10_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start));
  a_r10_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(trap) && $stable(cause)));
  a_r9_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cond_mask == 5'h00) |=> !trap);
  a_r9_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cond_mask == 5'h1f) |=> trap);
  a_r11_cause_code: assert property (@(posedge clk) disable iff (!rst_n)
    trap == (cause == TRAP_CODE));
  a_r7_word_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !dword && cond_mask == 5'h04 && opa[WORD_W-1:0] == opb[WORD_W-1:0]) |=> trap);
endmodule

// File: tb/trap_compare_test.sv
module trap_compare_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        dword = 1'b0;
  logic [63:0] opa = '0;
  logic [63:0] opb = '0;
  logic [4:0]  cond_mask = '0;
  logic        done, trap;
  logic [3:0]  cause;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  trap_compare uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dword(dword),
    .opa(opa), .opb(opb), .cond_mask(cond_mask),
    .done(done), .trap(trap), .cause(cause)
  );

  function automatic bit model(input logic [63:0] a, input logic [63:0] b,
                               input logic [4:0] m, input logic dw);
    bit lt_s, gt_s, eq, lt_u, gt_u;
    if (dw) begin
      logic signed [63:0] sa, sb;
      sa = a; sb = b;
      lt_s = sa < sb; gt_s = sa > sb;
      eq = a == b; lt_u = a < b; gt_u = a > b;
    end else begin
      logic signed [31:0] wa, wb;
      logic [31:0] ua, ub;
      wa = a[31:0]; wb = b[31:0]; ua = a[31:0]; ub = b[31:0];
      lt_s = wa < wb; gt_s = wa > wb;
      eq = ua == ub; lt_u = ua < ub; gt_u = ua > ub;
    end
    return (m[4] & lt_s) | (m[3] & gt_s) | (m[2] & eq) | (m[1] & lt_u) | (m[0] & gt_u);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [63:0] a, input logic [63:0] b, input logic [4:0] m,
                     input logic dw, input bit exp, input string req);
    @(negedge clk);
    start = 1'b1; opa = a; opb = b; cond_mask = m; dword = dw;
    @(negedge clk);
    start = 1'b0;
    chk(done === 1'b1, req, done, 1);
    chk(trap === exp, req, trap, exp);
    chk(cause === (exp ? 4'h2 : 4'h0), "R11", cause, exp ? 4'h2 : 4'h0);
  endtask

  task automatic t_reset;
    chk(done === 1'b0, "R12", done, 0);
    chk(trap === 1'b0, "R12", trap, 0);
    chk(cause === 4'h0, "R12", cause, 0);
  endtask

  task automatic t_signed_unsigned;
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'h10, 1'b1, 1, "R1");
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'h08, 1'b1, 0, "R2");
    run(64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 5'h08, 1'b1, 1, "R2");
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'h02, 1'b1, 0, "R4");
    run(64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 5'h02, 1'b1, 1, "R4");
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'h01, 1'b1, 1, "R5");
  endtask

  task automatic t_equal_or;
    run(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 5'h04, 1'b1, 1, "R3");
    run(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 5'h1b, 1'b1, 0, "R3");
    run(64'd5, 64'd9, 5'h0c, 1'b1, 0, "R6");
    run(64'd5, 64'd9, 5'h0e, 1'b1, 1, "R6");
  endtask

  task automatic t_width;
    run(64'hFFFF_FFFF_0000_0005, 64'h0000_0000_0000_0005, 5'h04, 1'b0, 1, "R7");
    run(64'hFFFF_FFFF_0000_0005, 64'h0000_0000_0000_0005, 5'h04, 1'b1, 0, "R8");
    run(64'h0000_0000_8000_0000, 64'd0, 5'h10, 1'b0, 1, "R7");
    run(64'h0000_0000_8000_0000, 64'd0, 5'h10, 1'b1, 0, "R8");
    run(64'h0000_0000_8000_0000, 64'd0, 5'h08, 1'b1, 1, "R8");
    run(64'h8000_0000_0000_0000, 64'd0, 5'h10, 1'b1, 1, "R8");
  endtask

  task automatic t_masks;
    run(64'd3, 64'd7, 5'h00, 1'b1, 0, "R9");
    run(64'd7, 64'd7, 5'h00, 1'b0, 0, "R9");
    run(64'd3, 64'd7, 5'h1f, 1'b1, 1, "R9");
    run(64'd7, 64'd7, 5'h1f, 1'b0, 1, "R9");
  endtask

  task automatic t_timing;
    run(64'd1, 64'd2, 5'h02, 1'b1, 1, "R10");
    @(negedge clk);
    chk(done === 1'b0, "R10", done, 0);
    chk(trap === 1'b1, "R10", trap, 1);
    opa = 64'd9; cond_mask = 5'h00;
    @(negedge clk);
    chk(trap === 1'b1, "R10", trap, 1);
    chk(cause === 4'h2, "R10", cause, 2);
  endtask

  task automatic t_random;
    for (int i = 0; i < 300; i++) begin
      logic [63:0] a, b;
      logic [4:0] m;
      logic dw;
      a = {$urandom, $urandom}; b = {$urandom, $urandom};
      if (i % 4 == 0) b = a;
      if (i % 5 == 0) b[31:0] = a[31:0];
      m = 5'($urandom); dw = 1'($urandom);
      run(a, b, m, dw, model(a, b, m, dw), "R6");
    end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_signed_unsigned();
    t_equal_or();
    t_width();
    t_masks();
    t_timing();
    t_random();
    finish_run();
  end
endmodule